// File: doc/BRIEF.md
# Four-Tributary Bit-Stuffing Multiplexer (Transmit)

This block forms the outgoing second-order serial frame from four independent lower-rate tributaries. It emits one line bit per clock. A frame is four subframes sent in order and then repeated. Each subframe has six blocks, and each block is one overhead bit followed by 48 information bits. The whole frame is 1176 bits long. The information bits are interleaved one bit at a time, in tributary order 1, 2, 3, 4. Tributaries 2 and 4 are inverted on the way in.

Each tributary is read from a small elastic buffer. The buffer offers a bit with a valid flag, and the block answers with a one-cycle read strobe in the clock where it takes that bit. Rate adaptation works by bit stuffing. At the start of subframe N, the block samples the stuff request of tributary N. That one decision sets the three stuff-control bits of the subframe. It also decides whether the dedicated slot in the last block of the subframe carries data or a dummy bit.

The alarm bit in the fourth subframe reports the remote framer's sync state. All remaining overhead bits follow fixed alignment patterns.

Top module: `bstuff_mux4`

## Requirements
- R1: While rst_n is low, the block drives line_out 0, line_sof 0 and trib_rd all zero. After release, the first line bit that appears is the first bit of a frame.
- R2: line_sof is high in exactly one cycle out of every 1176. In that cycle, line_out carries the first overhead bit of the frame. line_out lags the slot it encodes by one clock.
- R3: Within a block, information bit k (k = 1..48) belongs to tributary ((k-1) mod 4)+1. Tributary i's read strobe trib_rd[i-1] is asserted in the cycle that slot is formed, and at most one strobe is high in any cycle.
- R4: Data from tributaries 2 and 4 is sent inverted. Data from tributaries 1 and 3 is sent unchanged.
- R5: The overhead bit of block 1 is 0 in subframe 1 and 1 in subframes 2 and 3.
- R6: The overhead bit of block 3 is always 0. The overhead bit of block 6 is always 1.
- R7: The overhead bits of blocks 2, 4 and 5 all equal the stuff decision of the subframe. That decision is stuff_req[N-1], sampled in the first cycle of subframe N. Changes to stuff_req at other times have no effect on that subframe.
- R8: When stuffing is signalled in subframe N, information bit N of block 6 is a stuff bit. A stuff bit is sent as 0, and no read strobe is raised for it. Without stuffing, that slot is a normal data bit.
- R9: The overhead bit of block 1 in subframe 4 is 0 while remote_oos is 1, and 1 otherwise. remote_oos is sampled in that slot's cycle.
- R10: A data slot whose tributary has trib_valid low raises no read strobe. Its data value is taken as 0 before inversion.
- R11: No read strobe is raised in an overhead slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate clock, one line bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| trib_data | input | 4 | Head bit offered by each tributary buffer (bit 0 = tributary 1) |
| trib_valid | input | 4 | Head bit present, per tributary |
| stuff_req | input | 4 | Per-tributary request to stuff in its subframe |
| remote_oos | input | 1 | Remote framer out of sync |
| trib_rd | output | 4 | Read strobe, per tributary; the bit is taken at this clock edge |
| line_out | output | 1 | Registered serial line bit |
| line_sof | output | 1 | High with the first bit of each frame on line_out |

## Verification
On every cycle, the embedded properties check the following:
- at most one read strobe is high;
- no strobe is raised in an overhead slot or a stuff slot;
- the stuff slot falls on the lane of its own subframe;
- the stuff decision holds steady between subframe starts;
- the position counter stays in range and wraps to a frame start.

The bench scenarios are the only place where the actual line values are checked. That covers the interleaving order, the inversion of tributaries 2 and 4, the alignment patterns, the alarm bit, and the sampling instant of the stuff request. The bench checks these against an independent slot model. It uses random data and random valids, and adds directed frames with stuffing on every tributary, a forced alarm and starved buffers.

// File: rtl/bstuff_mux4_pkg.sv
// Package: shared frame geometry and slot classification for the
// four-tributary bit-stuffing multiplexer.
// Assumes: the tributary count equals the subframe count, so the stuff
// slot of subframe N always falls on tributary N's lane.
package bstuff_mux4_pkg;

    localparam int unsigned NUM_SUB   = 4;
    localparam int unsigned NUM_BLK   = 6;
    localparam int unsigned BLK_INFO  = 48;
    localparam int unsigned NUM_TRIB  = 4;

    // Kind of the slot currently being formed.
    typedef enum logic [1:0] {
        SLOT_OVH   = 2'd0,
        SLOT_DATA  = 2'd1,
        SLOT_STUFF = 2'd2
    } slot_kind_e;

    // Overhead role of a block's leading bit, indexed by block number.
    typedef enum logic [1:0] {
        OVH_ALIGN = 2'd0,
        OVH_CTRL  = 2'd1,
        OVH_ZERO  = 2'd2,
        OVH_ONE   = 2'd3
    } ovh_role_e;

    // Map a block index to the overhead role it carries.
    function automatic ovh_role_e role_of_block(input int unsigned blk);
        case (blk)
            0:       return OVH_ALIGN;
            2:       return OVH_ZERO;
            5:       return OVH_ONE;
            default: return OVH_CTRL;
        endcase
    endfunction

endpackage

// File: rtl/bstuff_frame_ctr.sv
// Frame position counter: walks the sub/block/bit coordinates of the
// multiplexed frame, one slot per clock.
// Assumes: bit index 0 is the overhead slot, 1..BLK_INFO are information.
module bstuff_frame_ctr #(
    parameter int unsigned N_SUB    = 4,
    parameter int unsigned N_BLK    = 6,
    parameter int unsigned INFO     = 48,
    localparam int unsigned SUB_W   = (N_SUB > 1) ? $clog2(N_SUB) : 1,
    localparam int unsigned BLK_W   = (N_BLK > 1) ? $clog2(N_BLK) : 1,
    localparam int unsigned BIT_W   = $clog2(INFO + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SUB_W-1:0] sub_idx,
    output logic [BLK_W-1:0] blk_idx,
    output logic [BIT_W-1:0] bit_idx,
    output logic             sub_start,
    output logic             frame_start
);

    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(N_SUB - 1);
    localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(N_BLK - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(INFO);

    logic blk_end;
    logic sub_end;

    assign blk_end     = (bit_idx == BIT_LAST);
    assign sub_end     = blk_end && (blk_idx == BLK_LAST);
    assign sub_start   = (bit_idx == '0) && (blk_idx == '0);
    assign frame_start = sub_start && (sub_idx == '0);

    // Advance the slot coordinates, wrapping bit, then block, then subframe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_idx <= '0;
            blk_idx <= '0;
            bit_idx <= '0;
        end else if (blk_end) begin
            bit_idx <= '0;
            if (blk_idx == BLK_LAST) begin
                blk_idx <= '0;
                sub_idx <= (sub_idx == SUB_LAST) ? '0 : sub_idx + 1'b1;
            end else begin
                blk_idx <= blk_idx + 1'b1;
            end
        end else begin
            bit_idx <= bit_idx + 1'b1;
        end
    end

    p_bit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= BIT_LAST);

    p_blk_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        blk_idx <= BLK_LAST);

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_end && sub_idx == SUB_LAST) |=> frame_start);

endmodule

// File: rtl/bstuff_ovh_gen.sv
// Overhead generator: forms the leading bit of each block from its role,
// the subframe index, the latched stuff decision and the remote alarm.
// Assumes: the last subframe carries the alarm in its alignment slot.
module bstuff_ovh_gen
    import bstuff_mux4_pkg::*;
#(
    parameter int unsigned N_SUB  = 4,
    parameter int unsigned N_BLK  = 6,
    localparam int unsigned SUB_W = (N_SUB > 1) ? $clog2(N_SUB) : 1,
    localparam int unsigned BLK_W = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
    input  logic [SUB_W-1:0] sub_idx,
    input  logic [BLK_W-1:0] blk_idx,
    input  logic             stuff_flag,
    input  logic             remote_oos,
    output logic             ovh_bit
);

    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(N_SUB - 1);

    ovh_role_e role;

    assign role = role_of_block(int'(blk_idx));

    // Choose the overhead value: alignment or alarm, control, or a fixed bit.
    always_comb begin
        case (role)
            OVH_ALIGN: begin
                if (sub_idx == SUB_LAST) ovh_bit = ~remote_oos;
                else                     ovh_bit = (sub_idx != '0);
            end
            OVH_CTRL:  ovh_bit = stuff_flag;
            OVH_ZERO:  ovh_bit = 1'b0;
            OVH_ONE:   ovh_bit = 1'b1;
            default:   ovh_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/bstuff_lane_sel.sv
// Lane selector: picks the tributary owning the current information slot,
// applies the per-lane inversion, detects the stuff slot and raises the
// read strobe.
// Assumes: NTRIB is a power of two; an empty buffer reads as 0.
module bstuff_lane_sel #(
    parameter int unsigned N_SUB    = 4,
    parameter int unsigned N_BLK    = 6,
    parameter int unsigned INFO     = 48,
    parameter int unsigned NTRIB    = 4,
    parameter logic [NTRIB-1:0] INV_MASK = 4'b1010,
    localparam int unsigned SUB_W   = (N_SUB > 1) ? $clog2(N_SUB) : 1,
    localparam int unsigned BLK_W   = (N_BLK > 1) ? $clog2(N_BLK) : 1,
    localparam int unsigned BIT_W   = $clog2(INFO + 1),
    localparam int unsigned LANE_W  = (NTRIB > 1) ? $clog2(NTRIB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUB_W-1:0] sub_idx,
    input  logic [BLK_W-1:0] blk_idx,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             stuff_flag,
    input  logic [NTRIB-1:0] lane_data,
    input  logic [NTRIB-1:0] lane_valid,
    output logic             is_data,
    output logic             is_stuff,
    output logic             data_bit,
    output logic [NTRIB-1:0] lane_rd
);

    localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(N_BLK - 1);

    logic [BIT_W-1:0]  info_off;
    logic [LANE_W-1:0] lane;
    logic              info_slot;
    logic [NTRIB-1:0]  lane_val;

    assign info_slot = (bit_idx != '0);
    assign info_off  = bit_idx - 1'b1;
    assign lane      = info_off[LANE_W-1:0];

    // Stuff slot: last block, stuffing signalled, offset equal to subframe.
    assign is_stuff = info_slot && stuff_flag && (blk_idx == BLK_LAST)
                      && (info_off == BIT_W'(sub_idx));
    assign is_data  = info_slot && !is_stuff;

    for (genvar g = 0; g < NTRIB; g++) begin : g_lane
        // Per-lane value after underrun fill and fixed inversion.
        assign lane_val[g] = (lane_valid[g] & lane_data[g]) ^ INV_MASK[g];
        // Per-lane strobe: owns the slot and has a bit to give.
        assign lane_rd[g]  = is_data && (lane == LANE_W'(g)) && lane_valid[g];
    end

    assign data_bit = is_data ? lane_val[lane] : 1'b0;

    p_rd_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_rd));

    p_stuff_no_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_stuff |-> (lane_rd == '0));

    p_stuff_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_stuff |-> (LANE_W'(sub_idx) == lane));

endmodule

// File: rtl/bstuff_mux4.sv
// Top: transmit side of the four-tributary bit-stuffing multiplexer.
// Latches the per-subframe stuff decision, merges overhead and data, and
// registers the serial line bit with a frame-start marker.
// Assumes: the tributary buffers accept a read strobe in the same cycle.
module bstuff_mux4
    import bstuff_mux4_pkg::*;
#(
    parameter int unsigned N_SUB  = NUM_SUB,
    parameter int unsigned N_BLK  = NUM_BLK,
    parameter int unsigned INFO   = BLK_INFO,
    parameter int unsigned NTRIB  = NUM_TRIB,
    localparam int unsigned SUB_W = (N_SUB > 1) ? $clog2(N_SUB) : 1,
    localparam int unsigned BLK_W = (N_BLK > 1) ? $clog2(N_BLK) : 1,
    localparam int unsigned BIT_W = $clog2(INFO + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIB-1:0] trib_data,
    input  logic [NTRIB-1:0] trib_valid,
    input  logic [NTRIB-1:0] stuff_req,
    input  logic             remote_oos,
    output logic [NTRIB-1:0] trib_rd,
    output logic             line_out,
    output logic             line_sof
);

    logic [SUB_W-1:0] sub_idx;
    logic [BLK_W-1:0] blk_idx;
    logic [BIT_W-1:0] bit_idx;
    logic             sub_start;
    logic             frame_start;
    logic             stuff_flag;
    logic             ovh_bit;
    logic             is_data;
    logic             is_stuff;
    logic             data_bit;
    logic [NTRIB-1:0] lane_rd;
    slot_kind_e       kind;

    bstuff_frame_ctr #(.N_SUB(N_SUB), .N_BLK(N_BLK), .INFO(INFO)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .sub_idx     (sub_idx),
        .blk_idx     (blk_idx),
        .bit_idx     (bit_idx),
        .sub_start   (sub_start),
        .frame_start (frame_start)
    );

    bstuff_ovh_gen #(.N_SUB(N_SUB), .N_BLK(N_BLK)) u_ovh (
        .sub_idx    (sub_idx),
        .blk_idx    (blk_idx),
        .stuff_flag (stuff_flag),
        .remote_oos (remote_oos),
        .ovh_bit    (ovh_bit)
    );

    bstuff_lane_sel #(.N_SUB(N_SUB), .N_BLK(N_BLK), .INFO(INFO),
                      .NTRIB(NTRIB)) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .sub_idx    (sub_idx),
        .blk_idx    (blk_idx),
        .bit_idx    (bit_idx),
        .stuff_flag (stuff_flag),
        .lane_data  (trib_data),
        .lane_valid (trib_valid),
        .is_data    (is_data),
        .is_stuff   (is_stuff),
        .data_bit   (data_bit),
        .lane_rd    (lane_rd)
    );

    // Classify the slot being formed this cycle.
    always_comb begin
        if (is_stuff)     kind = SLOT_STUFF;
        else if (is_data) kind = SLOT_DATA;
        else              kind = SLOT_OVH;
    end

    // Strobes are held low while in reset.
    assign trib_rd = rst_n ? lane_rd : '0;

    // Sample the owning tributary's stuff request once, at subframe start.
    always_ff @(posedge clk) begin
        if (!rst_n)         stuff_flag <= 1'b0;
        else if (sub_start) stuff_flag <= stuff_req[sub_idx];
    end

    // Register the selected line bit and the frame-start marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_out <= 1'b0;
            line_sof <= 1'b0;
        end else begin
            case (kind)
                SLOT_OVH:  line_out <= ovh_bit;
                SLOT_DATA: line_out <= data_bit;
                default:   line_out <= 1'b0;
            endcase
            line_sof <= frame_start;
        end
    end

    p_ovh_no_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_idx == '0) |-> (trib_rd == '0));

    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_start |=> $stable(stuff_flag));

    p_stuff_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SLOT_STUFF) |=> !line_out);

endmodule

// File: tb/sim_bstuff_mux4.sv
// Bench for the bit-stuffing multiplexer: seeded random traffic mixed with
// directed frames, compared slot by slot with a model held in the bench.
module sim_bstuff_mux4;

    localparam int FRAME = 1176;
    localparam int NFR   = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] trib_data = '0;
    logic [3:0] trib_valid = '0;
    logic [3:0] stuff_req = '0;
    logic       remote_oos = 1'b0;
    logic [3:0] trib_rd;
    logic       line_out;
    logic       line_sof;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    bstuff_mux4 u0 (
        .clk(clk), .rst_n(rst_n), .trib_data(trib_data),
        .trib_valid(trib_valid), .stuff_req(stuff_req),
        .remote_oos(remote_oos), .trib_rd(trib_rd),
        .line_out(line_out), .line_sof(line_sof)
    );

    task automatic check(input bit ok, input string req, input int act,
                         input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp,
                     $time);
        end
    endtask

    // Expected line bit for a slot; also returns the expected strobes and tag.
    function automatic bit exp_bit(input int k, input bit flag,
                                   input logic [3:0] d, input logic [3:0] v,
                                   input bit oos, output logic [3:0] rd,
                                   output string tag);
        int sub = k / 294;
        int r   = k % 294;
        int blk = r / 49;
        int b   = r % 49;
        int t;
        rd = '0;
        if (b == 0) begin
            case (blk)
                0: begin
                    if (sub == 3) begin tag = "R9"; return !oos; end
                    tag = "R5"; return (sub != 0);
                end
                2: begin tag = "R6"; return 1'b0; end
                5: begin tag = "R6"; return 1'b1; end
                default: begin tag = "R7"; return flag; end
            endcase
        end
        t = (b - 1) % 4;
        if (blk == 5 && flag && b == sub + 1) begin
            tag = "R8"; return 1'b0;
        end
        rd[t] = v[t];
        if (!v[t]) tag = "R10";
        else if (t % 2 == 1) tag = "R4";
        else tag = "R3";
        return (v[t] & d[t]) ^ (t % 2 == 1);
    endfunction

    initial begin
        int k;
        int fr;
        bit flag_m;
        bit exp_prev;
        bit sof_prev;
        string tag_prev;
        logic [3:0] rd_e;
        string tag;
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        check(line_out == 1'b0, "R1 line_out in reset", int'(line_out), 0);
        check(line_sof == 1'b0, "R1 line_sof in reset", int'(line_sof), 0);
        trib_valid = 4'hF;
        #1;
        check(trib_rd == 4'h0, "R1 trib_rd in reset", int'(trib_rd), 0);
        rst_n  = 1'b1;
        flag_m = 1'b0;
        exp_prev = 1'b0;
        sof_prev = 1'b0;
        tag_prev = "R1";
        for (int n = 0; n < NFR * FRAME; n++) begin
            k  = n % FRAME;
            fr = n / FRAME;
            if (n > 0) begin
                check(line_out == exp_prev, tag_prev, int'(line_out),
                      int'(exp_prev));
                check(line_sof == sof_prev, "R2 line_sof", int'(line_sof),
                      int'(sof_prev));
            end
            trib_data  = 4'($urandom);
            trib_valid = 4'($urandom) | 4'($urandom);
            stuff_req  = 4'($urandom);
            remote_oos = 1'($urandom);
            case (fr)
                1: begin stuff_req = 4'hF; trib_valid = 4'hF; end
                2: begin stuff_req = 4'h0; remote_oos = 1'b1; end
                3: trib_valid = 4'($urandom) & 4'($urandom);
                default: ;
            endcase
            #1;
            if ((k % 294) == 0) flag_m = stuff_req[k / 294];
            exp_prev = exp_bit(k, flag_m, trib_data, trib_valid, remote_oos,
                               rd_e, tag);
            tag_prev = (n == 0) ? "R1 first bit" : tag;
            sof_prev = (k == 0);
            check(trib_rd == rd_e, (k % 49 == 0) ? "R11 strobe" :
                  (tag == "R8") ? "R8 strobe" :
                  (tag == "R10") ? "R10 strobe" : "R3 strobe",
                  int'(trib_rd), int'(rd_e));
            @(negedge clk);
        end
        check(line_out == exp_prev, tag_prev, int'(line_out), int'(exp_prev));
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks,
                     fails);
            $finish;
        end
    end

endmodule